// File: doc/BRIEF.md
# Receive Packet Status Queue

This block sits between a receive MAC and the host side of a network controller. It holds the bytes of received packets in one byte FIFO and keeps one status entry per completed packet in a short queue. The host always sees one 16-bit status word. That word describes the oldest completed packet. When no completed packet is waiting, it describes the packet that is still arriving. The host pulls data bytes of the oldest packet one at a time. It drops that packet, together with any bytes not yet read, with a discard strobe.

The MAC side delivers bytes with a valid strobe. A last flag marks the final byte of a packet, and a 4-bit error code comes with that final byte. At the end of a packet the block checks its length against a minimum and a maximum. When either bound is broken and the MAC reported no error, the block replaces the code with a runt code or an oversize code.

A packet is admitted only if it fits whole. If it arrives while the status queue is full, or if the byte FIFO runs out of room at any point during it, the whole packet is dropped and no entry is made. The block has two flags that clear themselves:
- a status-overrun flag, high while the queue is full;
- a data-overrun flag, high while the FIFO is full.

Reading a byte that has not been received sets a sticky underrun flag and an adapter-failure output. Only a receive-reset command or the global reset clears them.

Top module: `rxq_status_queue`

## Requirements
- R1: While at least one completed packet is queued, `status_word` shows the oldest one: bit 15 = 0, bits 14:11 = its final error code, bits 10:0 = its byte count.
- R2: While no completed packet is queued, `status_word` has bit 15 = 1 and bits 14:11 = 0. Bits 10:0 hold the number of bytes received so far of an admitted packet in progress, or 0 when no such packet is in progress.
- R3: The final code of a packet is chosen in this order:
  - if the MAC code has bit 3 set, the MAC code is kept;
  - otherwise, if the length exceeds MAX_LEN, the code is 4'b1001 (oversize);
  - otherwise, if the length is below MIN_LEN, the code is 4'b1011 (runt);
  - otherwise the MAC code is kept.
- R4: A `rd_byte` pulse while the oldest packet still has unread bytes returns its next byte, in arrival order, on `rd_data`. `rd_valid` is high in the following cycle, and the read frees one FIFO byte.
- R5: A `discard` pulse removes the oldest entry and all of its unread bytes, so the next read returns the first byte of the next packet. A discard with an empty queue has no effect. When `discard` and `rd_byte` come in the same cycle, the discard wins and the read does nothing.
- R6: `stat_overrun` is high while the queue holds STAT_DEPTH entries. A packet that starts then is dropped whole. The flag drops after a discard.
- R7: `data_overrun` is high while the FIFO holds FIFO_DEPTH bytes. A packet that starts while the FIFO is full, or that meets a full FIFO partway through, is dropped whole: it leaves no entry and its stored bytes are released. The flag drops after a byte is read.
- R8: A `rd_byte` (without `discard`) when the oldest packet has no unread bytes, or when the queue is empty, returns no data. It sets `rx_underrun` and `adapter_fail`, which stay high until `rx_reset` or `rst`.
- R9: `receiving` is high from the cycle after the first admitted byte of a packet until the cycle after its last byte. It is never high while the status queue is full.
- R10: One `rx_reset` cycle empties the queue and the FIFO, closes any packet in progress, ignores a byte given in the same cycle, and clears every flag.
- R11: After `rst`, `status_word` = 16'h8000 and every flag and `rd_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high global reset |
| rx_vld | input | 1 | A receive byte is present |
| rx_data | input | 8 | Receive byte |
| rx_last | input | 1 | This byte ends the packet |
| rx_err | input | 4 | MAC error code, valid with rx_last |
| rd_byte | input | 1 | Host pops one byte of the oldest packet |
| discard | input | 1 | Host drops the oldest packet |
| rx_reset | input | 1 | Synchronous receive-path reset command |
| rd_data | output | 8 | Byte returned by a read |
| rd_valid | output | 1 | rd_data holds a byte from the previous cycle's read |
| status_word | output | 16 | Status of the oldest packet |
| receiving | output | 1 | An admitted packet is arriving |
| stat_overrun | output | 1 | Status queue full |
| data_overrun | output | 1 | Byte FIFO full |
| rx_underrun | output | 1 | Sticky over-read flag |
| adapter_fail | output | 1 | Failure indication raised by over-read |

## Verification
The bench builds the block with a 16-byte FIFO, a 4-entry queue, MIN_LEN = 2 and MAX_LEN = 10.

With these values, a sweep over every packet length from 1 to 11 and eight error codes lands on both classification boundaries. The sweep also checks every byte of every packet.

The small FIFO and queue make the full conditions easy to reach:
- two 8-byte packets fill the FIFO exactly;
- four short packets fill the queue;
- a 3-byte packet arriving with one byte of room left overflows partway through.

Together these exercise both drop paths and the self-clearing of both flags within a few dozen cycles.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  // Status word layout is fixed: 1 flag bit, 4 code bits, 11 length bits
  localparam int LEN_W  = 11;
  localparam int CODE_W = 4;

  localparam logic [CODE_W-1:0] CODE_OVERSIZE = 4'b1001;
  localparam logic [CODE_W-1:0] CODE_RUNT     = 4'b1011;

  typedef struct packed {
    logic [CODE_W-1:0] code;
    logic [LEN_W-1:0]  len;
  } rxq_entry_t;

  // MAC-reported errors (code bit 3) dominate, then the length checks
  function automatic logic [CODE_W-1:0] classify(
    input logic [CODE_W-1:0] mac_code,
    input logic [LEN_W-1:0]  len,
    input logic [LEN_W-1:0]  min_len,
    input logic [LEN_W-1:0]  max_len
  );
    if (mac_code[CODE_W-1])  return mac_code;
    else if (len > max_len)  return CODE_OVERSIZE;
    else if (len < min_len)  return CODE_RUNT;
    else                     return mac_code;
  endfunction

endpackage

// File: rtl/rxq_byte_ram.sv
module rxq_byte_ram #(
  parameter int DEPTH  = 2048,
  parameter int DATA_W = 8,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];

  // Simple dual port, registered read: maps onto block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/rxq_stat_fifo.sv
module rxq_stat_fifo #(
  parameter int DEPTH = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clr,
  input  logic                push,
  input  rxq_pkg::rxq_entry_t din,
  input  logic                pop,
  output rxq_pkg::rxq_entry_t head,
  output logic                empty,
  output logic                full
);

  rxq_pkg::rxq_entry_t mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] count;

  assign empty = (count == '0);
  assign full  = (count == CW'(DEPTH));
  assign head  = mem[rp];

  always_ff @(posedge clk) begin
    if (push && !clr) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R6
  no_push_full_chk: assert property (@(posedge clk) disable iff (rst)
    (push && !clr) |-> !full);

  // R5
  no_pop_empty_chk: assert property (@(posedge clk) disable iff (rst)
    (pop && !clr) |-> !empty);

endmodule

// File: rtl/rxq_status_queue.sv
module rxq_status_queue #(
  parameter int FIFO_DEPTH = 2048,
  parameter int STAT_DEPTH = 8,
  parameter int MIN_LEN    = 60,
  parameter int MAX_LEN    = 1514,
  localparam int FAW       = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1,
  localparam int LEN_W     = rxq_pkg::LEN_W
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        rx_vld,
  input  logic [7:0]  rx_data,
  input  logic        rx_last,
  input  logic [3:0]  rx_err,
  input  logic        rd_byte,
  input  logic        discard,
  input  logic        rx_reset,
  output logic [7:0]  rd_data,
  output logic        rd_valid,
  output logic [15:0] status_word,
  output logic        receiving,
  output logic        stat_overrun,
  output logic        data_overrun,
  output logic        rx_underrun,
  output logic        adapter_fail
);

  localparam logic [LEN_W-1:0] MIN_L    = LEN_W'(MIN_LEN);
  localparam logic [LEN_W-1:0] MAX_L    = LEN_W'(MAX_LEN);
  localparam logic [FAW:0]     FULL_CNT = (FAW+1)'(FIFO_DEPTH);

  // Byte FIFO pointers: write head, committed end, read head
  logic [FAW:0] wptr, cptr, rptr, used;
  logic         fifo_full;

  // Packet assembly state
  logic             in_pkt, dropping;
  logic [LEN_W-1:0] pkt_len, base_len, new_len;

  // Status queue interface
  rxq_pkg::rxq_entry_t push_entry, head;
  logic                q_empty, q_full;

  // Host side
  logic [LEN_W-1:0] top_used, top_rem;
  logic [FAW:0]     rem_ext;
  logic             byte_ok, rollback, commit, pop, do_read, underrun_evt;

  assign used      = wptr - rptr;
  assign fifo_full = (used == FULL_CNT);

  // A new packet needs queue and FIFO room; an open one needs FIFO room
  always_comb begin
    if (!in_pkt)       byte_ok = rx_vld && !fifo_full && !q_full;
    else if (dropping) byte_ok = 1'b0;
    else               byte_ok = rx_vld && !fifo_full;
  end

  assign rollback = rx_vld && in_pkt && !dropping && fifo_full;
  assign commit   = byte_ok && rx_last;

  assign base_len = in_pkt ? pkt_len : '0;
  assign new_len  = (base_len == '1) ? base_len : base_len + 1'b1;

  assign push_entry.len  = new_len;
  assign push_entry.code = rxq_pkg::classify(rx_err, new_len, MIN_L, MAX_L);

  assign top_rem      = q_empty ? '0 : head.len - top_used;
  assign rem_ext      = (FAW+1)'(top_rem);
  assign pop          = discard && !q_empty;
  assign do_read      = rd_byte && !discard && (top_rem != '0);
  assign underrun_evt = rd_byte && !discard && (top_rem == '0);

  rxq_stat_fifo #(.DEPTH(STAT_DEPTH)) u_stat (
    .clk   (clk),
    .rst   (rst),
    .clr   (rx_reset),
    .push  (commit),
    .din   (push_entry),
    .pop   (pop),
    .head  (head),
    .empty (q_empty),
    .full  (q_full)
  );

  rxq_byte_ram #(.DEPTH(FIFO_DEPTH), .DATA_W(8)) u_ram (
    .clk   (clk),
    .we    (byte_ok),
    .waddr (wptr[FAW-1:0]),
    .wdata (rx_data),
    .re    (do_read),
    .raddr (rptr[FAW-1:0]),
    .rdata (rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst || rx_reset) begin
      wptr        <= '0;
      cptr        <= '0;
      rptr        <= '0;
      in_pkt      <= 1'b0;
      dropping    <= 1'b0;
      pkt_len     <= '0;
      top_used    <= '0;
      rd_valid    <= 1'b0;
      rx_underrun <= 1'b0;
    end else begin
      rd_valid <= do_read;
      if (underrun_evt) rx_underrun <= 1'b1;

      // Write side: advance, or fall back to the last committed end
      if (byte_ok)       wptr <= wptr + 1'b1;
      else if (rollback) wptr <= cptr;
      if (commit)        cptr <= wptr + 1'b1;

      // Read side: a discard skips every unread byte of the top packet
      if (pop) begin
        rptr     <= rptr + rem_ext;
        top_used <= '0;
      end else if (do_read) begin
        rptr     <= rptr + 1'b1;
        top_used <= top_used + 1'b1;
      end

      if (rx_vld) begin
        if (rx_last) begin
          in_pkt   <= 1'b0;
          dropping <= 1'b0;
          pkt_len  <= '0;
        end else begin
          in_pkt <= 1'b1;
          if (byte_ok) begin
            pkt_len <= new_len;
          end else begin
            dropping <= 1'b1;
            pkt_len  <= '0;
          end
        end
      end
    end
  end

  assign receiving    = in_pkt && !dropping;
  assign stat_overrun = q_full;
  assign data_overrun = fifo_full;
  assign adapter_fail = rx_underrun;
  assign status_word  = q_empty ? {1'b1, 4'b0000, (receiving ? pkt_len : {LEN_W{1'b0}})}
                                : {1'b0, head.code, head.len};

  // R7
  fifo_bound_chk: assert property (@(posedge clk) disable iff (rst)
    used <= FULL_CNT);

  // R1
  top_bound_chk: assert property (@(posedge clk) disable iff (rst)
    !q_empty |-> (top_used <= head.len));

  // R8
  underrun_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_underrun && !rx_reset) |=> rx_underrun);

  // R9
  recv_room_chk: assert property (@(posedge clk) disable iff (rst)
    receiving |-> !stat_overrun);

  // R10
  rx_reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    rx_reset |=> (status_word == 16'h8000 && !rx_underrun && !data_overrun && !receiving));

endmodule

// File: tb/sim_rxq_status_queue.sv
module sim_rxq_status_queue;

  localparam int FD   = 16;
  localparam int SD   = 4;
  localparam int MINL = 2;
  localparam int MAXL = 10;

  logic        clk = 1'b0;
  logic        rst, rx_vld, rx_last, rd_byte, discard, rx_reset;
  logic [7:0]  rx_data;
  logic [3:0]  rx_err;
  logic [7:0]  rd_data;
  logic        rd_valid, receiving, stat_overrun, data_overrun, rx_underrun, adapter_fail;
  logic [15:0] status_word;

  always #5 clk = ~clk;

  rxq_status_queue #(.FIFO_DEPTH(FD), .STAT_DEPTH(SD), .MIN_LEN(MINL), .MAX_LEN(MAXL)) u0 (
    .clk(clk), .rst(rst), .rx_vld(rx_vld), .rx_data(rx_data), .rx_last(rx_last),
    .rx_err(rx_err), .rd_byte(rd_byte), .discard(discard), .rx_reset(rx_reset),
    .rd_data(rd_data), .rd_valid(rd_valid), .status_word(status_word),
    .receiving(receiving), .stat_overrun(stat_overrun), .data_overrun(data_overrun),
    .rx_underrun(rx_underrun), .adapter_fail(adapter_fail)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // Reference model of queued packets
  int q_len [8];
  int q_code[8];
  int q_id  [8];
  int qn = 0, used = 0, top_read = 0, next_id = 1;
  bit exp_under = 0;

  function automatic int pat(int id, int i);
    return (id * 37 + i * 11 + 5) & 255;
  endfunction

  function automatic int exp_code(int code, int len);
    if (code >= 8)   return code;
    if (len > MAXL)  return 9;
    if (len < MINL)  return 11;
    return code;
  endfunction

  function automatic int exp_status();
    if (qn == 0) return 16'h8000;
    return (q_code[0] << 11) | q_len[0];
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic model_pop();
    for (int k = 0; k < 7; k++) begin
      q_len[k] = q_len[k+1]; q_code[k] = q_code[k+1]; q_id[k] = q_id[k+1];
    end
    qn--;
    top_read = 0;
  endtask

  task automatic send_pkt(int len, int code);
    int id = next_id;
    bit start_ok = (qn < SD) && (used < FD);
    bit accepted = (qn < SD) && (used + len <= FD);
    next_id++;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (i == 1 && start_ok) begin
        chk("R9", "receiving mid-packet", int'(receiving), 1);
        if (qn == 0) chk("R2", "in-progress status", int'(status_word), 16'h8001);
      end
      rx_vld  = 1'b1;
      rx_data = 8'(pat(id, i));
      rx_last = (i == len - 1);
      rx_err  = 4'(code);
    end
    @(negedge clk);
    rx_vld = 1'b0; rx_last = 1'b0;
    if (accepted) begin
      q_len[qn] = len; q_code[qn] = exp_code(code, len); q_id[qn] = id;
      qn++;
      used += len;
    end
  endtask

  task automatic read_check(string req);
    @(negedge clk); rd_byte = 1'b1;
    @(negedge clk); rd_byte = 1'b0;
    if (qn > 0 && top_read < q_len[0]) begin
      chk(req, "rd_valid", int'(rd_valid), 1);
      chk(req, "rd_data", int'(rd_data), pat(q_id[0], top_read));
      top_read++;
      used--;
    end else begin
      chk(req, "rd_valid on over-read", int'(rd_valid), 0);
      exp_under = 1;
    end
    chk(req, "rx_underrun", int'(rx_underrun), int'(exp_under));
    chk(req, "adapter_fail", int'(adapter_fail), int'(exp_under));
  endtask

  task automatic discard_do();
    @(negedge clk); discard = 1'b1;
    @(negedge clk); discard = 1'b0;
    if (qn > 0) begin
      used -= q_len[0] - top_read;
      model_pop();
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R11 watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    automatic int codes[8] = '{0, 2, 8, 9, 11, 12, 13, 5};
    rst = 1'b1; rx_vld = 1'b0; rx_data = '0; rx_last = 1'b0; rx_err = '0;
    rd_byte = 1'b0; discard = 1'b0; rx_reset = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk("R11", "status", int'(status_word), 16'h8000);
    chk("R11", "receiving", int'(receiving), 0);
    chk("R11", "stat_overrun", int'(stat_overrun), 0);
    chk("R11", "data_overrun", int'(data_overrun), 0);
    chk("R11", "underrun", int'(rx_underrun), 0);
    chk("R11", "rd_valid", int'(rd_valid), 0);

    // Sweep lengths across both bounds and all code classes (R1, R3, R4, R5)
    for (int len = 1; len <= 11; len++) begin
      for (int c = 0; c < 8; c++) begin
        send_pkt(len, codes[c]);
        chk("R3", "classified status", int'(status_word), exp_status());
        chk("R9", "receiving after end", int'(receiving), 0);
        for (int k = 0; k < len; k++) read_check("R4");
        chk("R1", "status after reads", int'(status_word), exp_status());
        discard_do();
        chk("R5", "status after discard", int'(status_word), 16'h8000);
      end
    end

    // R5: discard with unread bytes, collision with read, empty discard
    send_pkt(5, 0);
    send_pkt(4, 2);
    read_check("R4");
    read_check("R4");
    discard_do();
    chk("R5", "next top status", int'(status_word), exp_status());
    read_check("R5");
    @(negedge clk); discard = 1'b1; rd_byte = 1'b1;
    @(negedge clk); discard = 1'b0; rd_byte = 1'b0;
    used -= q_len[0] - top_read; model_pop();
    chk("R5", "read ignored under discard", int'(rd_valid), 0);
    chk("R5", "no underrun under discard", int'(rx_underrun), 0);
    discard_do();
    chk("R5", "empty discard status", int'(status_word), 16'h8000);
    send_pkt(3, 0);
    read_check("R5");
    discard_do();

    // R6: status queue full
    for (int k = 0; k < SD; k++) send_pkt(2, 0);
    chk("R6", "stat_overrun set", int'(stat_overrun), 1);
    send_pkt(2, 2);
    chk("R6", "dropped packet leaves top", int'(status_word), exp_status());
    discard_do();
    chk("R6", "stat_overrun cleared", int'(stat_overrun), 0);
    read_check("R6");
    read_check("R6");
    while (qn > 0) begin
      chk("R6", "queued status", int'(status_word), exp_status());
      discard_do();
    end
    chk("R6", "drained", int'(status_word), 16'h8000);

    // R7: byte FIFO full, drop at start and mid-packet
    send_pkt(8, 0);
    send_pkt(8, 2);
    chk("R7", "data_overrun set", int'(data_overrun), 1);
    send_pkt(3, 0);
    chk("R7", "dropped at start", int'(status_word), exp_status());
    read_check("R7");
    chk("R7", "data_overrun cleared", int'(data_overrun), 0);
    send_pkt(3, 0);
    chk("R7", "mid-packet drop frees space", int'(data_overrun), 0);
    chk("R7", "mid-packet drop no entry", int'(status_word), exp_status());
    discard_do();
    chk("R7", "second packet status", int'(status_word), exp_status());
    read_check("R7");
    discard_do();
    send_pkt(4, 0);
    for (int k = 0; k < 4; k++) read_check("R7");
    discard_do();
    chk("R7", "empty after drain", int'(status_word), 16'h8000);

    // R8: over-read of a packet, then of an empty queue
    send_pkt(2, 0);
    read_check("R8");
    read_check("R8");
    read_check("R8");
    discard_do();
    read_check("R8");
    send_pkt(3, 0);
    read_check("R8");

    // R10: receive reset mid-packet with a byte in the same cycle
    send_pkt(4, 0);
    @(negedge clk); rx_vld = 1'b1; rx_data = 8'h11; rx_last = 1'b0;
    @(negedge clk);
    chk("R9", "receiving before reset", int'(receiving), 1);
    rx_reset = 1'b1; rx_data = 8'h22;
    @(negedge clk); rx_reset = 1'b0; rx_vld = 1'b0;
    qn = 0; used = 0; top_read = 0; exp_under = 0;
    chk("R10", "status", int'(status_word), 16'h8000);
    chk("R10", "underrun", int'(rx_underrun), 0);
    chk("R10", "adapter_fail", int'(adapter_fail), 0);
    chk("R10", "receiving", int'(receiving), 0);
    chk("R10", "data_overrun", int'(data_overrun), 0);
    chk("R10", "stat_overrun", int'(stat_overrun), 0);
    send_pkt(3, 0);
    chk("R10", "fresh packet status", int'(status_word), exp_status());
    for (int k = 0; k < 3; k++) read_check("R10");
    discard_do();

    summary();
  end

endmodule